// File: doc/BRIEF.md
# DSP Data Address Generator

This block computes data memory addresses from a private pointer register, so that a signal processing core never spends its arithmetic datapath on address math. Each cycle the request strobe is high, the unit emits one address and moves the pointer. The step is plus or minus one or a signed programmable modifier. The new pointer can be used before the address is issued (pre-modify) or after it (post-modify).

Two further step rules serve filter and transform loops. The circular rule keeps the pointer inside a buffer given by a base and a length. The bit-reversed rule adds the modifier with the carry running from the highest selected bit down toward bit 0. This walks through a power-of-two table in the order a radix-2 FFT needs. The memory and the instruction decode sit outside the block.

Top module: `dsp_agu`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first request, `addr_vld` is 0 and `addr` is 0. The pointer and the modifier reset to 0.
- R2: When `ptr_ld` is high, the pointer takes `ptr_val` at the clock edge. This takes priority over `req`: no address is issued for that cycle, so `addr_vld` is 0 in the following cycle.
- R3: A request (`req` high, `ptr_ld` low) makes `addr_vld` high with its address exactly one cycle later. A cycle with neither `req` nor `ptr_ld` leaves the pointer unchanged and gives `addr_vld` 0 in the next cycle.
- R4: Mode 0 issues the pointer and then adds 1 to it. Mode 1 issues the pointer and then subtracts 1.
- R5: Mode 2 issues the pointer and then adds the modifier, read as a two's complement value. The result wraps modulo 2^16.
- R6: In the pre-modify modes the pointer is first updated and the updated value is issued. Mode 3 adds the modifier, mode 6 adds 1 and mode 7 subtracts 1.
- R7: Mode 4 issues the pointer and then adds the signed modifier inside the buffer [`buf_base`, `buf_base`+`buf_len`-1]. A result above the top has `buf_len` subtracted. A result below `buf_base` has `buf_len` added. This assumes the pointer is inside the buffer and the step magnitude does not exceed `buf_len`.
- R8: Mode 5 issues the pointer. It then adds the modifier over the low `rev_width` bits, with the carry moving from bit `rev_width`-1 toward bit 0 and dropped past bit 0. Bits at and above `rev_width` stay unchanged.
- R9: When `mod_ld` is high, the modifier takes `mod_val` at the edge. A request in the same cycle still uses the old modifier. Loading the modifier never moves the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_ld | input | 1 | Load the pointer from `ptr_val` |
| ptr_val | input | 16 | Pointer load value |
| mod_ld | input | 1 | Load the modifier from `mod_val` |
| mod_val | input | 16 | Modifier load value (two's complement) |
| mode | input | 3 | Step rule select, codes 0 to 7 as in R4 to R8 |
| buf_base | input | 16 | Lowest address of the circular buffer |
| buf_len | input | 16 | Circular buffer length, 1 or more |
| rev_width | input | 5 | Number of low bits stepped in bit-reversed mode |
| req | input | 1 | Request one address this cycle |
| addr | output | 16 | Issued address |
| addr_vld | output | 1 | `addr` holds a new address |

## Verification
Every address is due exactly one cycle after the request that asked for it. The pointer and modifier loads show their effect on the first request made after their edge. The driver keeps a model of the pointer and the modifier. For each accepted request it queues the expected address, tagged with the cycle in which it is due and with its requirement. The monitor samples at the falling edge. In a cycle where an entry is due, it demands `addr_vld` and the address of that entry. In every other cycle it demands that `addr_vld` is low. This catches a late, early, missing or extra address as well as a wrong one.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_POST_INC = 3'd0,
    AM_POST_DEC = 3'd1,
    AM_POST_MOD = 3'd2,
    AM_PRE_MOD  = 3'd3,
    AM_CIRC     = 3'd4,
    AM_BREV     = 3'd5,
    AM_PRE_INC  = 3'd6,
    AM_PRE_DEC  = 3'd7
  } agu_mode_e;

endpackage

// File: rtl/agu_step.sv
module agu_step
  import agu_pkg::*;
#(
  parameter int AW = 16,
  localparam int RW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] ptr_q,
  input  logic [AW-1:0] mod_q,
  input  agu_mode_e     mode,
  input  logic [AW-1:0] buf_base,
  input  logic [AW-1:0] buf_len,
  input  logic [RW-1:0] rev_width,
  output logic [AW-1:0] addr_nxt,
  output logic [AW-1:0] ptr_nxt,
  output logic [AW-1:0] rev_mask
);

  // carry runs from the top selected bit down to bit 0
  function automatic logic [AW-1:0] rev_carry_add(input logic [AW-1:0] a,
                                                 input logic [AW-1:0] b,
                                                 input logic [RW-1:0] w);
    logic [AW-1:0] r;
    logic c;
    r = a;
    c = 1'b0;
    for (int i = AW - 1; i >= 0; i--) begin
      if (i < int'(w)) begin
        r[i] = a[i] ^ b[i] ^ c;
        c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
      end
    end
    return r;
  endfunction

  // signed step folded back into [base, base+len-1]
  function automatic logic [AW-1:0] circ_add(input logic [AW-1:0] p,
                                            input logic [AW-1:0] s,
                                            input logic [AW-1:0] base,
                                            input logic [AW-1:0] len);
    logic signed [AW+1:0] sum, lo, hi, ln;
    sum = $signed({2'b00, p}) + $signed({{2{s[AW-1]}}, s});
    lo  = $signed({2'b00, base});
    ln  = $signed({2'b00, len});
    hi  = lo + ln - 1;
    if (!s[AW-1] && (sum > hi))      sum = sum - ln;
    else if (s[AW-1] && (sum < lo))  sum = sum + ln;
    return sum[AW-1:0];
  endfunction

  for (genvar g = 0; g < AW; g++) begin : g_mask
    assign rev_mask[g] = (g < int'(rev_width));
  end

  always_comb begin
    addr_nxt = ptr_q;
    ptr_nxt  = ptr_q;
    unique case (mode)
      AM_POST_INC: ptr_nxt = ptr_q + 1'b1;
      AM_POST_DEC: ptr_nxt = ptr_q - 1'b1;
      AM_POST_MOD: ptr_nxt = ptr_q + mod_q;
      AM_PRE_MOD: begin
        ptr_nxt  = ptr_q + mod_q;
        addr_nxt = ptr_nxt;
      end
      AM_CIRC:     ptr_nxt = circ_add(ptr_q, mod_q, buf_base, buf_len);
      AM_BREV:     ptr_nxt = rev_carry_add(ptr_q, mod_q, rev_width);
      AM_PRE_INC: begin
        ptr_nxt  = ptr_q + 1'b1;
        addr_nxt = ptr_nxt;
      end
      AM_PRE_DEC: begin
        ptr_nxt  = ptr_q - 1'b1;
        addr_nxt = ptr_nxt;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/agu_regs.sv
module agu_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_val,
  input  logic          mod_ld,
  input  logic [AW-1:0] mod_val,
  input  logic          take_req,
  input  logic [AW-1:0] ptr_nxt,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] mod_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      mod_q <= '0;
    end else begin
      if (ptr_ld)        ptr_q <= ptr_val;
      else if (take_req) ptr_q <= ptr_nxt;
      if (mod_ld)        mod_q <= mod_val;
    end
  end

  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> ptr_q == $past(ptr_val));
  a_r9_mod_load: assert property (@(posedge clk) disable iff (!rst_n)
    mod_ld |=> mod_q == $past(mod_val));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_ld && !take_req) |=> ptr_q == $past(ptr_q));

endmodule

// File: rtl/agu_out.sv
module agu_out #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_req,
  input  logic [AW-1:0] addr_nxt,
  output logic [AW-1:0] addr_q,
  output logic          vld_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= take_req;
      if (take_req) addr_q <= addr_nxt;
    end
  end

  a_r3_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> vld_q);
  a_r3_no_vld_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !take_req |=> !vld_q);

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int AW = 16,
  localparam int RW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_val,
  input  logic          mod_ld,
  input  logic [AW-1:0] mod_val,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] buf_base,
  input  logic [AW-1:0] buf_len,
  input  logic [RW-1:0] rev_width,
  input  logic          req,
  output logic [AW-1:0] addr,
  output logic          addr_vld
);

  agu_mode_e     mode_e;
  logic          take_req;
  logic [AW-1:0] ptr_q, mod_q, ptr_nxt, addr_nxt, rev_mask;

  assign mode_e   = agu_mode_e'(mode);
  assign take_req = req & ~ptr_ld;

  agu_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .mod_ld(mod_ld), .mod_val(mod_val),
    .take_req(take_req), .ptr_nxt(ptr_nxt),
    .ptr_q(ptr_q), .mod_q(mod_q)
  );

  agu_step #(.AW(AW)) u_step (
    .ptr_q(ptr_q), .mod_q(mod_q), .mode(mode_e),
    .buf_base(buf_base), .buf_len(buf_len), .rev_width(rev_width),
    .addr_nxt(addr_nxt), .ptr_nxt(ptr_nxt), .rev_mask(rev_mask)
  );

  agu_out #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .take_req(take_req), .addr_nxt(addr_nxt),
    .addr_q(addr), .vld_q(addr_vld)
  );

  // named events for the checks below
  logic          ev_post_inc, ev_circ, ev_brev, ptr_in_buf, step_fits;
  logic [AW:0]   buf_top;
  logic [AW-1:0] step_mag;

  assign ev_post_inc = take_req && (mode_e == AM_POST_INC);
  assign ev_circ     = take_req && (mode_e == AM_CIRC);
  assign ev_brev     = take_req && (mode_e == AM_BREV);
  assign buf_top     = {1'b0, buf_base} + {1'b0, buf_len};
  assign ptr_in_buf  = (ptr_q >= buf_base) && ({1'b0, ptr_q} < buf_top);
  assign step_mag    = mod_q[AW-1] ? (~mod_q + 1'b1) : mod_q;
  assign step_fits   = (step_mag <= buf_len) && (buf_len != '0);

  a_r4_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_post_inc |=> (addr == $past(ptr_q)) && (ptr_q == $past(ptr_q) + 1'b1));
  a_r7_stay_in_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_circ && ptr_in_buf && step_fits) |=>
      (!$stable(buf_base) || !$stable(buf_len) || ptr_in_buf));
  a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brev |=> ((ptr_q & ~$past(rev_mask)) == ($past(ptr_q) & ~$past(rev_mask))));
  a_r2_load_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> !addr_vld);

endmodule

// File: tb/dsp_agu_bench.sv
module dsp_agu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        ptr_ld = 0, mod_ld = 0, req = 0;
  logic [15:0] ptr_val = 0, mod_val = 0, buf_base = 0, buf_len = 1;
  logic [2:0]  mode = 0;
  logic [4:0]  rev_width = 0;
  logic [15:0] addr;
  logic        addr_vld;

  dsp_agu u_dsp_agu (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {int due; logic [15:0] a; string tag;} item_t;
  item_t sb[$];
  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] m_ptr = 0, m_mod = 0;
  bit monitor_on = 0;

  function automatic int revb(int x, int w);
    int r = 0;
    for (int i = 0; i < w; i++) if ((x >> i) & 1) r |= 1 << (w - 1 - i);
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // driver: one cycle of stimulus plus its expected result
  task automatic drive(int md, bit rq, bit pl, logic [15:0] pv, bit ml, logic [15:0] mv, string tag);
    logic [15:0] a, n;
    int sm, off, msk;
    @(negedge clk); #1;
    mode = md[2:0]; req = rq; ptr_ld = pl; ptr_val = pv; mod_ld = ml; mod_val = mv;
    if (rq && !pl) begin
      sm = int'($signed(m_mod));
      a = m_ptr; n = m_ptr;
      case (md)
        0: n = m_ptr + 16'd1;
        1: n = m_ptr - 16'd1;
        2: n = m_ptr + m_mod;
        3: begin n = m_ptr + m_mod; a = n; end
        4: begin
          off = int'(m_ptr) - int'(buf_base) + sm;
          off = ((off % int'(buf_len)) + int'(buf_len)) % int'(buf_len);
          n = buf_base + 16'(off);
        end
        5: begin
          msk = (1 << rev_width) - 1;
          off = revb((revb(int'(m_ptr) & msk, rev_width) + revb(int'(m_mod) & msk, rev_width)) & msk, rev_width);
          n = (m_ptr & ~16'(msk)) | 16'(off);
        end
        6: begin n = m_ptr + 16'd1; a = n; end
        default: begin n = m_ptr - 16'd1; a = n; end
      endcase
      sb.push_back('{cyc + 1, a, tag});
      m_ptr = n;
    end
    if (pl) m_ptr = pv;
    if (ml) m_mod = mv;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, "R3");
  endtask

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (monitor_on) begin
        cyc++;
        if (sb.size() > 0 && sb[0].due == cyc) begin
          check({sb[0].tag, " vld"}, addr_vld, 1);
          check({sb[0].tag, " addr"}, addr, sb[0].a);
          void'(sb.pop_front());
        end else if (addr_vld !== 1'b0) begin
          check("R3/R2 spurious vld", addr_vld, 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 vld in reset", addr_vld, 0);
    check("R1 addr in reset", addr, 0);
    @(negedge clk); #1; rst_n = 1;
    @(negedge clk);
    check("R1 vld after reset", addr_vld, 0);
    monitor_on = 1;
    // reset pointer is 0: first post-increment issues 0
    drive(0, 1, 0, 0, 0, 0, "R1");
    // R4: increment and decrement by one
    drive(0, 0, 1, 16'h0010, 0, 0, "R2");
    drive(0, 1, 0, 0, 0, 0, "R4");
    drive(0, 1, 0, 0, 0, 0, "R4");
    drive(0, 1, 0, 0, 0, 0, "R4");
    drive(1, 1, 0, 0, 0, 0, "R4");
    drive(1, 1, 0, 0, 0, 0, "R4");
    // R2: load wins over a request in the same cycle
    drive(0, 1, 1, 16'h0050, 0, 0, "R2");
    drive(0, 1, 0, 0, 0, 0, "R2");
    idle(2);
    // R9: modifier load with a request in the same cycle uses the old one
    drive(2, 1, 0, 0, 1, 16'hFFFD, "R9");
    drive(2, 1, 0, 0, 0, 0, "R5");
    drive(2, 1, 0, 0, 0, 0, "R5");
    drive(2, 0, 1, 16'h0001, 0, 0, "R2");
    drive(2, 1, 0, 0, 0, 0, "R5");
    drive(2, 1, 0, 0, 0, 0, "R5");
    // R6: pre-modify forms
    drive(3, 0, 0, 0, 1, 16'h0005, "R9");
    drive(3, 1, 0, 0, 0, 0, "R6");
    drive(3, 1, 0, 0, 0, 0, "R6");
    drive(6, 1, 0, 0, 0, 0, "R6");
    drive(7, 1, 0, 0, 0, 0, "R6");
    drive(7, 1, 0, 0, 0, 0, "R6");
    // R7: circular buffer forward and backward
    buf_base = 16'h0100; buf_len = 16'd8;
    drive(4, 0, 1, 16'h0100, 1, 16'h0003, "R2");
    for (int i = 0; i < 6; i++) drive(4, 1, 0, 0, 0, 0, "R7");
    drive(4, 0, 0, 0, 1, 16'hFFFD, "R9");
    for (int i = 0; i < 6; i++) drive(4, 1, 0, 0, 0, 0, "R7");
    drive(4, 0, 1, 16'h0107, 1, 16'h0008, "R2");
    drive(4, 1, 0, 0, 0, 0, "R7");
    drive(4, 1, 0, 0, 0, 0, "R7");
    // R8: reverse-carry stepping at two widths
    rev_width = 5'd3;
    drive(5, 0, 1, 16'h0200, 1, 16'h0004, "R2");
    for (int i = 0; i < 9; i++) drive(5, 1, 0, 0, 0, 0, "R8");
    rev_width = 5'd4;
    drive(5, 0, 1, 16'hA3F0, 1, 16'h0008, "R2");
    for (int i = 0; i < 17; i++) drive(5, 1, 0, 0, 0, 0, "R8");
    rev_width = 5'd16;
    drive(5, 0, 1, 16'h0000, 1, 16'h8000, "R2");
    for (int i = 0; i < 4; i++) drive(5, 1, 0, 0, 0, 0, "R8");
    // R3: idle cycles do not move the pointer
    idle(3);
    drive(0, 1, 0, 0, 0, 0, "R3");
    idle(3);
    check("R3 queue drained", sb.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule